// File: doc/BRIEF.md
# Serial Audio Slot Port

This block is the serial side of a two-channel audio codec port. It runs entirely in one system-clock domain. The serial bit clock reaches it as two single-cycle enables from outside: one for the rising edge and one for the falling edge. A frame-sync input marks the start of each frame, and a single data line runs in each direction. Channel 0 is the left slot and channel 1 is the right slot. Each channel has its own start position for receive and for transmit, counted in bit clocks from the frame-sync rising edge. Each also has its own word length and its own bit order.

Received bits are sampled on the rising edge of the bit clock. When a channel's last bit has been taken, the assembled word appears on a parallel output together with a one-cycle strobe. Transmit words come from parallel inputs and are captured at the frame-sync edge. They are launched on falling edges, and the output enable is raised only while a transmit slot is active. This leaves the line free for other devices on a shared bus. A control input holds the line released at all times. The bit counter restarts at every frame-sync edge, so a short or irregular frame does not leave the port out of step.

Top module: `sport_port`

## Requirements
- R1: After reset, sdout_oe and sdout_data are 0 and no rx_valid bit is set.
- R2: Receive, MSB first. With rx_lsb at 0, the bit sampled at position rx_off+i (i from 0 to L-1) lands at bit L-1-i of rx_word. Position 0 is the rising-bit-clock enable on which fsync is first seen high after being low.
- R3: Receive, LSB first. With rx_lsb at 1 and an effective length of 24 or fewer, the bit sampled at position rx_off+i lands at bit i of rx_word.
- R4: A request for LSB-first order with an effective length above 24 is carried out as MSB first, in both directions.
- R5: Transmit, MSB first. For i from 0 to L-1, bit L-1-i of the transmit word is driven on sdout_data, with sdout_oe at 1, from the falling-edge enable after rise position tx_off+i. It holds until the next falling-edge enable.
- R6: Transmit, LSB first, with an effective length of 24 or fewer. Bit i of the transmit word is driven after rise position tx_off+i.
- R7: After a falling-edge enable that follows a position outside every transmit slot, sdout_oe is 0. This includes every position before the first frame-sync edge. Channel 0 wins where the two transmit slots overlap.
- R8: While force_hiz is 1, sdout_oe is 0 and receive is unaffected.
- R9: rx_valid[c] is high for exactly one cycle, the cycle right after the rise enable that sampled the last bit of channel c. Only then does rx_word[c] change.
- R10: A frame-sync edge restarts the bit position at 0 even when it comes in the middle of a word. The next full frame is then received and sent correctly.
- R11: The transmit word is captured at the frame-sync edge. Changes on tx_word later in the frame have no effect on that frame.
- R12: A length field (6 bits) below 8 is treated as 8, and one above 32 is treated as 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_rise_en | input | 1 | One-cycle pulse per rising bit-clock edge |
| bclk_fall_en | input | 1 | One-cycle pulse per falling bit-clock edge |
| fsync | input | 1 | Frame sync; its rising edge starts a frame |
| sdin | input | 1 | Serial receive data |
| force_hiz | input | 1 | Keep the data output released |
| rx_off | input | NCH x 7 | Receive start position per channel |
| rx_len | input | NCH x 6 | Receive word length per channel |
| rx_lsb | input | NCH | Receive LSB-first request per channel |
| tx_off | input | NCH x 7 | Transmit start position per channel |
| tx_len | input | NCH x 6 | Transmit word length per channel |
| tx_lsb | input | NCH | Transmit LSB-first request per channel |
| tx_word | input | NCH x 32 | Transmit word per channel |
| rx_word | output | NCH x 32 | Last received word per channel |
| rx_valid | output | NCH | One-cycle strobe per completed receive word |
| sdout_data | output | 1 | Serial transmit data |
| sdout_oe | output | 1 | Output enable for the data line driver; 0 means high impedance |

## Verification
Some properties are checked on every cycle: the quiet state after reset, the forced release, the single-cycle strobe that follows a rise enable, and the rule that the output and its enable move only on falling-edge enables. Bit placement, order, slot windows, length clamping, the LSB-first limit, capture of the transmit word at the frame-sync edge and recovery after a truncated frame depend on the frame's history. Only the bench scenarios show these, by comparing against words computed from the driven bit stream.

// File: rtl/sport_pkg.sv
package sport_pkg;

    localparam int POS_W   = 7;
    localparam int LEN_W   = 6;
    localparam int WORD_W  = 32;
    localparam int MIN_LEN = 8;
    localparam int LSB_MAX = 24;

    typedef logic [POS_W-1:0]  pos_t;
    typedef logic [LEN_W-1:0]  len_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        pos_t off;
        len_t len;
        logic lsb;
    } lane_cfg_t;

    function automatic len_t clamp_len(len_t l);
        if (l < len_t'(MIN_LEN)) return len_t'(MIN_LEN);
        if (l > len_t'(WORD_W))  return len_t'(WORD_W);
        return l;
    endfunction

    function automatic logic eff_lsb(lane_cfg_t c);
        return c.lsb && (clamp_len(c.len) <= len_t'(LSB_MAX));
    endfunction

    function automatic logic [POS_W:0] win_end(lane_cfg_t c);
        return {1'b0, c.off} + (POS_W+1)'(clamp_len(c.len));
    endfunction

    function automatic logic in_window(pos_t p, lane_cfg_t c);
        return ({1'b0, p} >= {1'b0, c.off}) && ({1'b0, p} < win_end(c));
    endfunction

    function automatic logic is_last(pos_t p, lane_cfg_t c);
        return ({1'b0, p} == (win_end(c) - (POS_W+1)'(1)));
    endfunction

endpackage

// File: rtl/sport_framer.sv
module sport_framer
    import sport_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rise_en,
    input  logic fsync,
    output logic sof,
    output logic cur_ok,
    output pos_t cur_pos,
    output logic run,
    output pos_t last_pos
);
    localparam pos_t POS_MAX = '1;

    logic fs_q;
    pos_t cnt;

    assign sof      = rise_en && fsync && !fs_q;
    assign cur_ok   = sof || (run && cnt != POS_MAX);
    assign cur_pos  = sof ? '0 : cnt + pos_t'(1);
    assign last_pos = cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_q <= 1'b0;
            cnt  <= '0;
            run  <= 1'b0;
        end else if (rise_en) begin
            fs_q <= fsync;
            if (sof) begin
                cnt <= '0;
                run <= 1'b1;
            end else if (run) begin
                if (cnt == POS_MAX) run <= 1'b0;
                else                cnt <= cnt + pos_t'(1);
            end
        end
    end
endmodule

// File: rtl/sport_rx_lane.sv
module sport_rx_lane
    import sport_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rise_en,
    input  logic      pos_ok,
    input  pos_t      pos,
    input  logic      sdin,
    input  lane_cfg_t cfg,
    output word_t     word,
    output logic      valid
);
    word_t shreg, nxt, mask;
    len_t  len_e;
    logic  lsb_e, take, last;

    assign len_e = clamp_len(cfg.len);
    assign lsb_e = eff_lsb(cfg);
    assign take  = rise_en && pos_ok && in_window(pos, cfg);
    assign last  = take && is_last(pos, cfg);
    assign nxt   = lsb_e ? {sdin, shreg[WORD_W-1:1]} : {shreg[WORD_W-2:0], sdin};
    assign mask  = (word_t'(1) << len_e) - word_t'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            word  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= last;
            if (take) shreg <= nxt;
            if (last) word <= lsb_e ? (nxt >> (len_t'(WORD_W) - len_e)) : (nxt & mask);
        end
    end
endmodule

// File: rtl/sport_tx_lane.sv
module sport_tx_lane
    import sport_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sof,
    input  logic      run,
    input  pos_t      last_pos,
    input  word_t     tx_word,
    input  lane_cfg_t cfg,
    output logic      active,
    output logic      bit_o
);
    word_t word_q;
    pos_t  rel, rev, idx;

    assign rel    = last_pos - cfg.off;
    assign rev    = pos_t'(clamp_len(cfg.len)) - pos_t'(1) - rel;
    assign idx    = eff_lsb(cfg) ? rel : rev;
    assign active = run && in_window(last_pos, cfg);
    assign bit_o  = |(word_q & (word_t'(1) << idx));

    always_ff @(posedge clk) begin
        if (rst)      word_q <= '0;
        else if (sof) word_q <= tx_word;
    end
endmodule

// File: rtl/sport_port.sv
module sport_port
    import sport_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bclk_rise_en,
    input  logic                        bclk_fall_en,
    input  logic                        fsync,
    input  logic                        sdin,
    input  logic                        force_hiz,
    input  logic [NCH-1:0][POS_W-1:0]   rx_off,
    input  logic [NCH-1:0][LEN_W-1:0]   rx_len,
    input  logic [NCH-1:0]              rx_lsb,
    input  logic [NCH-1:0][POS_W-1:0]   tx_off,
    input  logic [NCH-1:0][LEN_W-1:0]   tx_len,
    input  logic [NCH-1:0]              tx_lsb,
    input  logic [NCH-1:0][WORD_W-1:0]  tx_word,
    output logic [NCH-1:0][WORD_W-1:0]  rx_word,
    output logic [NCH-1:0]              rx_valid,
    output logic                        sdout_data,
    output logic                        sdout_oe
);
    logic sof, cur_ok, run;
    pos_t cur_pos, last_pos;
    logic [NCH-1:0] act, bits;
    logic sel_act, sel_bit, oe_q, dat_q;

    sport_framer u_framer (
        .clk(clk), .rst(rst), .rise_en(bclk_rise_en), .fsync(fsync),
        .sof(sof), .cur_ok(cur_ok), .cur_pos(cur_pos),
        .run(run), .last_pos(last_pos)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        lane_cfg_t rcfg, tcfg;
        assign rcfg = '{off: rx_off[c], len: rx_len[c], lsb: rx_lsb[c]};
        assign tcfg = '{off: tx_off[c], len: tx_len[c], lsb: tx_lsb[c]};

        sport_rx_lane u_rx (
            .clk(clk), .rst(rst), .rise_en(bclk_rise_en), .pos_ok(cur_ok),
            .pos(cur_pos), .sdin(sdin), .cfg(rcfg),
            .word(rx_word[c]), .valid(rx_valid[c])
        );

        sport_tx_lane u_tx (
            .clk(clk), .rst(rst), .sof(sof), .run(run), .last_pos(last_pos),
            .tx_word(tx_word[c]), .cfg(tcfg),
            .active(act[c]), .bit_o(bits[c])
        );
    end

    // lowest channel index wins where slots overlap
    always_comb begin
        sel_act = 1'b0;
        sel_bit = 1'b0;
        for (int c = NCH-1; c >= 0; c--) begin
            if (act[c]) begin
                sel_act = 1'b1;
                sel_bit = bits[c];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q  <= 1'b0;
            dat_q <= 1'b0;
        end else if (bclk_fall_en) begin
            oe_q  <= sel_act;
            dat_q <= sel_act & sel_bit;
        end
    end

    assign sdout_oe   = oe_q & ~force_hiz;
    assign sdout_data = dat_q;
endmodule

// File: rtl/sport_checker.sv
module sport_checker #(
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst,
    input logic           bclk_rise_en,
    input logic           bclk_fall_en,
    input logic           force_hiz,
    input logic [NCH-1:0] rx_valid,
    input logic           sdout_data,
    input logic           sdout_oe
);
    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sdout_oe && !sdout_data && rx_valid == '0));

    assert_forced_release_R8: assert property (@(posedge clk) disable iff (rst)
        force_hiz |-> !sdout_oe);

    assert_data_moves_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(bclk_fall_en) |-> $stable(sdout_data));

    assert_oe_moves_on_fall_R7: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sdout_oe) && $stable(force_hiz)) |-> $past(bclk_fall_en));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        assert_valid_single_R9: assert property (@(posedge clk) disable iff (rst)
            rx_valid[c] |=> !rx_valid[c]);
        assert_valid_after_rise_R9: assert property (@(posedge clk) disable iff (rst)
            $rose(rx_valid[c]) |-> $past(bclk_rise_en));
    end
endmodule

bind sport_port sport_checker #(.NCH(NCH)) u_chk (
    .clk(clk), .rst(rst), .bclk_rise_en(bclk_rise_en), .bclk_fall_en(bclk_fall_en),
    .force_hiz(force_hiz), .rx_valid(rx_valid), .sdout_data(sdout_data),
    .sdout_oe(sdout_oe)
);

// File: tb/tb_sport_port.sv
module tb_sport_port;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bclk_rise_en = 1'b0, bclk_fall_en = 1'b0, fsync = 1'b0, sdin = 1'b0, force_hiz = 1'b0;
    logic [1:0][6:0]  rx_off = '0, tx_off = '0;
    logic [1:0][5:0]  rx_len = '0, tx_len = '0;
    logic [1:0]       rx_lsb = '0, tx_lsb = '0;
    logic [1:0][31:0] tx_word = '0;
    logic [1:0][31:0] rx_word;
    logic [1:0]       rx_valid;
    logic sdout_data, sdout_oe;

    always #4 clk = ~clk;

    sport_port #(.NCH(2)) dut (
        .clk(clk), .rst(rst), .bclk_rise_en(bclk_rise_en), .bclk_fall_en(bclk_fall_en),
        .fsync(fsync), .sdin(sdin), .force_hiz(force_hiz),
        .rx_off(rx_off), .rx_len(rx_len), .rx_lsb(rx_lsb),
        .tx_off(tx_off), .tx_len(tx_len), .tx_lsb(tx_lsb), .tx_word(tx_word),
        .rx_word(rx_word), .rx_valid(rx_valid), .sdout_data(sdout_data), .sdout_oe(sdout_oe)
    );

    int n_total = 0, n_bad = 0;
    int rxo[2], rxl[2], txo[2], txl[2];
    bit rxs[2], txs[2];
    logic [31:0] tw[2];
    bit bits[0:127];
    logic [15:0] lfsr = 16'hACE1;
    string ftag = "";

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
        n_total++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic int eff_len(int raw);
        if (raw < 8) return 8;
        if (raw > 32) return 32;
        return raw;
    endfunction

    function automatic bit eff_lsb(bit s, int raw);
        return s && (eff_len(raw) <= 24);
    endfunction

    function automatic string tag_for(bit s, int raw);
        if (ftag != "") return ftag;
        if (raw < 8 || raw > 32) return "R12";
        if (s && eff_len(raw) > 24) return "R4";
        return "";
    endfunction

    function automatic logic [31:0] exp_rx(int ch);
        logic [31:0] v = '0;
        int L = eff_len(rxl[ch]);
        for (int i = 0; i < L; i++) begin
            if (eff_lsb(rxs[ch], rxl[ch])) v[i] = bits[rxo[ch]+i];
            else v[L-1-i] = bits[rxo[ch]+i];
        end
        return v;
    endfunction

    task automatic apply_cfg();
        for (int c = 0; c < 2; c++) begin
            rx_off[c] = 7'(rxo[c]); rx_len[c] = 6'(rxl[c]); rx_lsb[c] = rxs[c];
            tx_off[c] = 7'(txo[c]); tx_len[c] = 6'(txl[c]); tx_lsb[c] = txs[c];
        end
    endtask

    task automatic run_frame(int F, bit nosync, bit swap);
        for (int p = 0; p < F; p++) begin
            bit fs, d, eo, ed;
            string t;
            fs = nosync ? 1'b0 : (p < (F+1)/2);
            d = lfsr[0];
            lfsr = {lfsr[14:0], lfsr[15]^lfsr[13]^lfsr[12]^lfsr[10]};
            bits[p] = d;
            @(negedge clk);
            fsync = fs; sdin = d; bclk_rise_en = 1'b1;
            if (p == 0) begin tx_word[0] = tw[0]; tx_word[1] = tw[1]; end
            @(negedge clk);
            bclk_rise_en = 1'b0;
            for (int c = 0; c < 2; c++) begin
                bit ev;
                ev = !nosync && (p == rxo[c] + eff_len(rxl[c]) - 1);
                t = tag_for(rxs[c], rxl[c]);
                if (t == "") t = eff_lsb(rxs[c], rxl[c]) ? "R3" : "R2";
                chk(nosync ? "R7" : "R9", 32'(rx_valid[c]), 32'(ev), $sformatf("rx_valid ch%0d pos %0d", c, p));
                if (ev) chk(t, rx_word[c], exp_rx(c), $sformatf("rx_word ch%0d", c));
            end
            if (swap && p == 2) begin tx_word[0] = ~tw[0]; tx_word[1] = ~tw[1]; end
            @(negedge clk);
            chk("R9", 32'(rx_valid), 32'd0, $sformatf("rx_valid drop pos %0d", p));
            bclk_fall_en = 1'b1;
            @(negedge clk);
            bclk_fall_en = 1'b0;
            eo = 1'b0; ed = 1'b0; t = "R7";
            for (int c = 1; c >= 0; c--) begin
                int L, i;
                L = eff_len(txl[c]);
                i = p - txo[c];
                if (!nosync && i >= 0 && i < L) begin
                    eo = 1'b1;
                    ed = eff_lsb(txs[c], txl[c]) ? tw[c][i] : tw[c][L-1-i];
                    t = tag_for(txs[c], txl[c]);
                    if (t == "") t = eff_lsb(txs[c], txl[c]) ? "R6" : "R5";
                end
            end
            if (swap) t = "R11";
            if (force_hiz) t = "R8";
            chk(t, 32'(sdout_oe), 32'(eo && !force_hiz), $sformatf("oe pos %0d", p));
            if (eo && !force_hiz) chk(t, 32'(sdout_data), 32'(ed), $sformatf("data pos %0d", p));
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_total++; n_bad++;
        $display("FAIL watchdog expired act=running exp=done");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: quiet state after reset
        chk("R1", 32'(sdout_oe), 32'd0, "oe after reset");
        chk("R1", 32'(sdout_data), 32'd0, "data after reset");
        chk("R1", 32'(rx_valid), 32'd0, "rx_valid after reset");

        rxo = '{0, 40}; rxl = '{16, 16}; rxs = '{0, 0};
        txo = '{0, 40}; txl = '{16, 16}; txs = '{0, 0};
        tw = '{32'h1234_5678, 32'h9ABC_DEF0};
        apply_cfg();
        run_frame(6, 1'b1, 1'b0);   // R7: no activity before first frame sync

        for (int k = 0; k < 16; k++) begin
            rxo[0] = k % 5;        rxl[0] = 8 + (k*7) % 25;     rxs[0] = k[0];
            txo[0] = (k*3) % 7;    txl[0] = 8 + (k*11) % 25;    txs[0] = k[1];
            rxo[1] = 40 + k % 3;   rxl[1] = 8 + (k*5+3) % 25;   rxs[1] = k[2];
            txo[1] = 40 + (k*2) % 5; txl[1] = 8 + (k*13+1) % 25; txs[1] = k[3];
            tw[0] = 32'h9E37_79B9 * (k+1);
            tw[1] = 32'h7F4A_7C15 ^ (k * 32'h0101_0101);
            apply_cfg();
            run_frame(80, 1'b0, 1'b0);
        end

        // R12: length fields outside 8..32
        rxl = '{3, 40}; txl = '{63, 5}; rxs = '{1, 1}; txs = '{0, 1};
        rxo = '{2, 41}; txo = '{1, 44};
        apply_cfg();
        ftag = "R12";
        run_frame(80, 1'b0, 1'b0);
        ftag = "";

        // R8: forced release, receive continues
        rxl = '{20, 12}; txl = '{20, 12}; rxs = '{1, 0}; txs = '{1, 0};
        rxo = '{3, 45}; txo = '{5, 42};
        apply_cfg();
        force_hiz = 1'b1;
        run_frame(80, 1'b0, 1'b0);
        force_hiz = 1'b0;

        // R11: tx_word changed mid frame
        run_frame(80, 1'b0, 1'b1);

        // R10: truncated frame mid word, then a full frame
        rxo = '{3, 40}; rxl = '{12, 10}; txo = '{4, 41}; txl = '{16, 9};
        apply_cfg();
        ftag = "R10";
        run_frame(10, 1'b0, 1'b0);
        run_frame(80, 1'b0, 1'b0);
        ftag = "";

        finish_run();
    end
endmodule